// File: doc/BRIEF.md
# Play/Stop Power Sequencing Controller

This controller takes a battery-powered device from fully off to running and back again. A press of the play button, seen as a falling edge, switches on the DC-to-DC converter. The controller then waits until the 1.8 V and the 3.3 V supply comparators both report good, raises a supply-ok output, and keeps the system reset (active low) asserted for a programmable number of clock cycles. Once reset is released and the core clock reports stable, the converter's clock select moves from the ring oscillator to the core clock. One cycle after that, a started output goes high.

A high level on the stop input overrides everything and returns the device to off. If a supply comparator drops while the device is up, the controller falls back to waiting for supply with the converter still on. The converter, the comparators and the oscillators are represented only by input flags. All inputs pass through two-flop synchronisers, and all outputs come from registers.

Top module: `play_stop_sequencer`

## Requirements
- R1: While reset is asserted and directly after it, convEnable, supplyOk, sysRstN, clkSelCore and started are all 0.
- R2: In the off state, a high-to-low transition on playBtn sets convEnable on the third rising clock edge after the input changes, because two synchroniser stages sit in front of the controller. A low-to-high transition on playBtn has no effect.
- R3: supplyOk rises only while both good18 and good33 are high. In the wait-for-supply state, any other combination of the two flags leaves it at 0.
- R4: sysRstN stays 0 for exactly RST_DELAY_CYCLES clock cycles after supplyOk rises, and then goes to 1.
- R5: Falling edges on playBtn are ignored while convEnable is 1, and every output keeps its value.
- R6: clkSelCore goes to 1 only after sysRstN is 1 and coreClkStable has been seen high. The latency is three edges from the input change.
- R7: started goes to 1 one clock cycle after clkSelCore goes to 1, and it is never 1 while clkSelCore is 0.
- R8: If good18 or good33 drops after supplyOk has risen, then supplyOk, sysRstN, clkSelCore and started all go to 0 and convEnable stays 1. When both flags return, the sequence restarts with a new full reset delay.
- R9: A high stopReq clears all five outputs on the third edge after it rises, in every state. While stopReq is high, play edges are ignored. After stopReq is released, the controller stays off until the next play edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| playBtn | input | 1 | Play button; a falling edge starts the device |
| stopReq | input | 1 | Stop request, level sensitive, highest priority |
| good18 | input | 1 | 1.8 V supply-good comparator flag |
| good33 | input | 1 | 3.3 V supply-good comparator flag |
| coreClkStable | input | 1 | Core clock stable flag |
| convEnable | output | 1 | DC-to-DC converter enable |
| supplyOk | output | 1 | Both supplies qualified |
| sysRstN | output | 1 | Active-low system reset |
| clkSelCore | output | 1 | Converter clock select: 0 = ring oscillator, 1 = core clock |
| started | output | 1 | Device is fully started |

## Verification
The hardest cases to reach from the ports are a stop request or a supply loss that arrives in one of the intermediate states: while the reset delay is counting, or while the controller waits for the core clock. Each of these states lasts only as long as the stimulus holds it. The bench therefore uses a staged bring-up loop. It drives the device to each depth in turn (waiting for supply, holding reset, waiting for clock, running), checks the outputs expected at that depth, and then applies stop. Supply loss is provoked from the running state, and the bench also checks that a full new reset delay follows when the supplies recover.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_SUPPLY,
    ST_RESET_HOLD,
    ST_WAIT_CLK,
    ST_RUN
  } seqState_e;

  // One-cycle strobes from the control FSM to the output datapath
  typedef struct packed {
    logic enConv;
    logic clrAll;
    logic supplyUp;
    logic supplyDown;
    logic releaseRst;
    logic selCore;
  } seqStrobe_t;

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      logic [WIDTH-1:0] stageIn;
      if (g == 0) begin : gFirst
        assign stageIn = dIn;
      end else begin : gRest
        assign stageIn = pipe[g-1];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[g] <= '0;
        else       pipe[g] <= stageIn;
      end
    end
  endgenerate

  assign dOut = pipe[STAGES-1];

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       playS,
  input  logic       stopS,
  input  logic       good18S,
  input  logic       good33S,
  input  logic       clkStableS,
  input  logic       delayDone,
  output seqStrobe_t strobe
);

  seqState_e state, nextState;
  logic      playPrev;
  logic      playFall;
  logic      bothGood;

  assign playFall = playPrev & ~playS;
  assign bothGood = good18S & good33S;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OFF;
      playPrev <= 1'b0;
    end else begin
      state    <= nextState;
      playPrev <= playS;
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (stopS) begin
      nextState     = ST_OFF;
      strobe.clrAll = 1'b1;
    end else begin
      unique case (state)
        ST_OFF: begin
          if (playFall) begin
            nextState     = ST_WAIT_SUPPLY;
            strobe.enConv = 1'b1;
          end
        end
        ST_WAIT_SUPPLY: begin
          if (bothGood) begin
            nextState       = ST_RESET_HOLD;
            strobe.supplyUp = 1'b1;
          end
        end
        ST_RESET_HOLD: begin
          if (!bothGood) begin
            nextState         = ST_WAIT_SUPPLY;
            strobe.supplyDown = 1'b1;
          end else if (delayDone) begin
            nextState         = ST_WAIT_CLK;
            strobe.releaseRst = 1'b1;
          end
        end
        ST_WAIT_CLK: begin
          if (!bothGood) begin
            nextState         = ST_WAIT_SUPPLY;
            strobe.supplyDown = 1'b1;
          end else if (clkStableS) begin
            nextState      = ST_RUN;
            strobe.selCore = 1'b1;
          end
        end
        ST_RUN: begin
          if (!bothGood) begin
            nextState         = ST_WAIT_SUPPLY;
            strobe.supplyDown = 1'b1;
          end
        end
        default: begin
          nextState     = ST_OFF;
          strobe.clrAll = 1'b1;
        end
      endcase
    end
  end

  // R9
  stop_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopS |=> state == ST_OFF);

  // R5
  play_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_OFF && !stopS) |=> state != ST_OFF);

  // R3
  supply_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_SUPPLY && !stopS && !(good18S && good33S)) |=> state == ST_WAIT_SUPPLY);

endmodule

// File: rtl/pwrseq_dp.sv
module pwrseq_dp
  import pwrseq_pkg::*;
#(
  parameter int unsigned RST_DELAY_CYCLES = 50_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic       delayDone,
  output logic       convEnable,
  output logic       supplyOk,
  output logic       sysRstN,
  output logic       clkSelCore,
  output logic       started
);

  localparam int unsigned CNT_W   = (RST_DELAY_CYCLES > 1) ? $clog2(RST_DELAY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_DELAY_CYCLES - 1);

  logic [CNT_W-1:0] delayCnt;
  logic             dropDown;

  assign dropDown  = strobe.clrAll | strobe.supplyDown;
  assign delayDone = (delayCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  delayCnt <= '0;
    else if (strobe.supplyUp)   delayCnt <= CNT_LOAD;
    else if (delayCnt != '0)    delayCnt <= delayCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convEnable <= 1'b0;
      supplyOk   <= 1'b0;
      sysRstN    <= 1'b0;
      clkSelCore <= 1'b0;
      started    <= 1'b0;
    end else begin
      if (strobe.clrAll)       convEnable <= 1'b0;
      else if (strobe.enConv)  convEnable <= 1'b1;

      if (dropDown)              supplyOk <= 1'b0;
      else if (strobe.supplyUp)  supplyOk <= 1'b1;

      if (dropDown)                sysRstN <= 1'b0;
      else if (strobe.releaseRst)  sysRstN <= 1'b1;

      if (dropDown)             clkSelCore <= 1'b0;
      else if (strobe.selCore)  clkSelCore <= 1'b1;

      if (dropDown) started <= 1'b0;
      else          started <= clkSelCore;
    end
  end

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    delayCnt <= CNT_LOAD);

  // R4
  reset_after_supply_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstN) |-> supplyOk);

  // R6
  sel_needs_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkSelCore |-> sysRstN);

  // R7
  started_after_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    started |-> clkSelCore);

  // R8
  supply_implies_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    supplyOk |-> convEnable);

endmodule

// File: rtl/play_stop_sequencer.sv
module play_stop_sequencer
  import pwrseq_pkg::*;
#(
  parameter int unsigned RST_DELAY_CYCLES = 50_000,
  parameter int          SYNC_STAGES      = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic playBtn,
  input  logic stopReq,
  input  logic good18,
  input  logic good33,
  input  logic coreClkStable,
  output logic convEnable,
  output logic supplyOk,
  output logic sysRstN,
  output logic clkSelCore,
  output logic started
);

  localparam int N_IN = 5;

  logic [N_IN-1:0] rawIn, syncIn;
  seqStrobe_t      strobe;
  logic            delayDone;

  assign rawIn = {coreClkStable, good33, good18, stopReq, playBtn};

  pwrseq_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (rawIn),
    .dOut (syncIn)
  );

  pwrseq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .playS      (syncIn[0]),
    .stopS      (syncIn[1]),
    .good18S    (syncIn[2]),
    .good33S    (syncIn[3]),
    .clkStableS (syncIn[4]),
    .delayDone  (delayDone),
    .strobe     (strobe)
  );

  pwrseq_dp #(.RST_DELAY_CYCLES(RST_DELAY_CYCLES)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .delayDone  (delayDone),
    .convEnable (convEnable),
    .supplyOk   (supplyOk),
    .sysRstN    (sysRstN),
    .clkSelCore (clkSelCore),
    .started    (started)
  );

endmodule

// File: tb/test_play_stop_sequencer.sv
module test_play_stop_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int DELAY      = 6;
  localparam int LAT        = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic playBtn = 1'b0, stopReq = 1'b0, good18 = 1'b0, good33 = 1'b0, coreClkStable = 1'b0;
  logic convEnable, supplyOk, sysRstN, clkSelCore, started;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  play_stop_sequencer #(.RST_DELAY_CYCLES(DELAY), .SYNC_STAGES(2)) i_play_stop_sequencer (
    .clk(clk), .rstN(rstN), .playBtn(playBtn), .stopReq(stopReq),
    .good18(good18), .good33(good33), .coreClkStable(coreClkStable),
    .convEnable(convEnable), .supplyOk(supplyOk), .sysRstN(sysRstN),
    .clkSelCore(clkSelCore), .started(started)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Output vector order: {convEnable, supplyOk, sysRstN, clkSelCore, started}
  task automatic chk(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {convEnable, supplyOk, sysRstN, clkSelCore, started};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic playPress();
    playBtn = 1'b1;
    tick(LAT);
    playBtn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 during reset", 5'b00000);
    rstN = 1'b1;
    tick(1);
    chk("R1 after reset", 5'b00000);

    // R2: a rising edge does nothing, a falling edge enables after LAT edges
    playBtn = 1'b1;
    tick(5);
    chk("R2 rising edge ignored", 5'b00000);
    playBtn = 1'b0;
    tick(LAT - 1);
    chk("R2 before latency", 5'b00000);
    tick(1);
    chk("R2 enable on falling edge", 5'b10000);

    // R3: sweep the supply flag combinations
    for (int c = 0; c < 3; c++) begin
      {good18, good33} = 2'(c);
      tick(LAT + 1);
      chk("R3 partial supply", 5'b10000);
    end
    {good18, good33} = 2'b11;
    tick(LAT - 1);
    chk("R3 before latency", 5'b10000);
    tick(1);
    chk("R3 both good", 5'b11000);

    // R4: reset delay
    tick(DELAY - 1);
    chk("R4 still in reset", 5'b11000);
    tick(1);
    chk("R4 reset released", 5'b11100);

    // R5: play edge while enabled
    playPress();
    tick(LAT + 1);
    chk("R5 play ignored", 5'b11100);

    // R6 / R7: clock handover then started
    coreClkStable = 1'b1;
    tick(LAT - 1);
    chk("R6 before latency", 5'b11100);
    tick(1);
    chk("R6 select core, R7 not yet started", 5'b11110);
    tick(1);
    chk("R7 started", 5'b11111);

    // R8: supply loss and recovery
    good33 = 1'b0;
    tick(LAT - 1);
    chk("R8 before latency", 5'b11111);
    tick(1);
    chk("R8 supply lost, converter kept", 5'b10000);
    good33 = 1'b1;
    tick(LAT);
    chk("R8 supply back", 5'b11000);
    tick(DELAY - 1);
    chk("R8 fresh reset delay", 5'b11000);
    tick(1);
    chk("R8 reset released again", 5'b11100);
    tick(1);
    chk("R8 select core again", 5'b11110);
    tick(1);
    chk("R8 started again", 5'b11111);

    // R9: stop in run, play ignored while stop high, stays off after release
    stopReq = 1'b1;
    tick(LAT - 1);
    chk("R9 before latency", 5'b11111);
    tick(1);
    chk("R9 stop clears all", 5'b00000);
    playPress();
    tick(LAT + 1);
    chk("R9 play ignored under stop", 5'b00000);
    stopReq = 1'b0;
    tick(LAT + 2);
    chk("R9 stays off after release", 5'b00000);

    // R9: stop applied at each depth of bring-up
    for (int s = 0; s < 4; s++) begin
      logic [4:0] expStage;
      good18 = 1'b0; good33 = 1'b0; coreClkStable = 1'b0;
      tick(LAT);
      playPress();
      tick(LAT);
      expStage = 5'b10000;
      if (s >= 1) begin
        {good18, good33} = 2'b11;
        tick(LAT);
        expStage = 5'b11000;
      end
      if (s >= 2) begin
        tick(DELAY);
        expStage = 5'b11100;
      end
      if (s >= 3) begin
        coreClkStable = 1'b1;
        tick(LAT + 1);
        expStage = 5'b11111;
      end
      chk("R9 stage reached before stop", expStage);
      stopReq = 1'b1;
      tick(LAT);
      chk("R9 stop at stage", 5'b00000);
      stopReq = 1'b0;
      tick(LAT + 1);
      chk("R9 off after stop at stage", 5'b00000);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule